// File: doc/BRIEF.md
# Framed Packet Transmit Sequencer

This block turns bytes waiting in a transmit FIFO into framed serial packets of a fixed, host-programmed length. A start strobe from the host arms one transmission. The block first shifts out a run of alternating-bit preamble bytes and a 16-bit sync word. It then sends up to four header bytes and an optional length byte, both taken from configuration inputs. Last come exactly the programmed number of payload bytes, popped from the FIFO. Every byte goes out most significant bit first, one bit per clock, each bit marked by a valid strobe.

When the last payload bit has gone out, the sequencer returns to idle by itself and raises a sticky packet-sent flag. Bytes still in the FIFO stay there until the host issues another start, so one FIFO fill can be split into several packets by repeated start commands. The FIFO can run dry in the middle of a payload. In that case the packet is cut short, the block goes idle and it raises an underflow flag in place of the packet-sent flag. The configuration is snapshotted when a start is accepted, so the host may prepare the next packet's settings while the current one is on the line.

Top module: `pkt_tx_seq`

## Requirements
- R1: A start strobe seen while idle is accepted at that clock edge. The first frame bit appears on `tx_bit_o` with `tx_vld_o` high in the very next cycle. Bits then follow one per clock, each byte most significant bit first, with `tx_vld_o` high for every frame bit.
- R2: Every frame opens with `cfg_pre_len` preamble bytes of value 0xAA (a value of 0 sends one byte). The two bytes of `cfg_sync` follow, high byte first.
- R3: After the sync word come `cfg_hdr_len` header bytes. With n header bytes, the byte sent at position i (from 0) is `cfg_hdr[8*(n-1-i) +: 8]`. A length of 0 sends no header, and values above 4 are treated as 4.
- R4: When `cfg_len_en` is 1, one byte equal to `cfg_pkt_len` follows the header. When it is 0, no length byte is sent.
- R5: After the length byte (or the header if the length byte is off) come exactly `cfg_pkt_len` payload bytes. Each is the FIFO head byte, and `fifo_rd_o` pulses once for each of them. A length of 0 sends no payload. `tx_busy_o` stays high from the cycle after the start until the cycle after the last frame bit, then drops with no host action.
- R6: FIFO bytes beyond the programmed length are not sent until the next start. With a length of 3 and nine bytes queued, three starts give three packets carrying bytes 1-3, 4-6 and 7-9 in turn, and the line stays silent between them.
- R7: `irq_sent_o` is set in the cycle after the last bit of a completed packet and stays set until a cycle with `irq_rd_i` high. If completion and `irq_rd_i` fall in the same cycle, the flag ends up set.
- R8: If the FIFO is empty when a payload byte is due, the frame stops after the bits already sent and the block goes idle. `irq_unf_o` is then set, `irq_sent_o` is not set, and `irq_rd_i` clears `irq_unf_o` in the same way as `irq_sent_o`.
- R9: A start strobe while busy has no effect. Configuration changes made while busy do not alter the packet in progress.
- R10: During and right after reset, `tx_vld_o`, `tx_bit_o`, `tx_busy_o`, `fifo_rd_o`, `irq_sent_o` and `irq_unf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Host start strobe |
| irq_rd_i | input | 1 | Host read strobe, clears both flags |
| cfg_pre_len | input | PRE_W (4) | Preamble byte count |
| cfg_sync | input | SYNC_W (16) | Sync word |
| cfg_hdr_len | input | HLEN_W (3) | Header byte count |
| cfg_hdr | input | 8*HDR_MAX (32) | Header byte source |
| cfg_len_en | input | 1 | Send the length byte |
| cfg_pkt_len | input | LEN_W (8) | Payload byte count |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_data_i | input | 8 | FIFO head byte (show-ahead) |
| fifo_rd_o | output | 1 | Pop the FIFO head |
| tx_bit_o | output | 1 | Serial data bit |
| tx_vld_o | output | 1 | Serial bit valid |
| tx_busy_o | output | 1 | Transmission in progress |
| irq_sent_o | output | 1 | Sticky packet-sent flag |
| irq_unf_o | output | 1 | Sticky FIFO underflow flag |

## Verification
The host read strobe and the end of a packet can fall in the same cycle, so a clear and a set of the packet-sent flag meet on one edge. The bench leaves the flag set from an earlier packet. It then raises the read strobe in exactly the cycle that shows the last frame bit, and expects the flag still set afterwards. A lone strobe later must clear it. A start strobe issued mid-frame is a second collision, this time with a busy sequencer. It is judged by the frame's exact bit content and by a silent line after the frame ends.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

  // Frame section currently on the line; F_IDLE doubles as "no frame".
  typedef enum logic [2:0] {
    F_IDLE = 3'd0,
    F_PRE  = 3'd1,
    F_SYNC = 3'd2,
    F_HDR  = 3'd3,
    F_LEN  = 3'd4,
    F_PAY  = 3'd5
  } field_e;

  localparam logic [7:0] PRE_BYTE = 8'hAA;
  localparam int         BYTE_W   = 8;

endpackage

// File: rtl/pkt_tx_cfg_hold.sv
module pkt_tx_cfg_hold #(
  parameter int PRE_W   = 4,
  parameter int HDR_MAX = 4,
  parameter int SYNC_W  = 16,
  parameter int LEN_W   = 8,
  localparam int HLEN_W = $clog2(HDR_MAX + 1),
  localparam int HDR_W  = 8 * HDR_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [PRE_W-1:0]  pre_len_in,
  input  logic [SYNC_W-1:0] sync_in,
  input  logic [HLEN_W-1:0] hdr_len_in,
  input  logic [HDR_W-1:0]  hdr_in,
  input  logic              len_en_in,
  input  logic [LEN_W-1:0]  pkt_len_in,
  output logic [PRE_W-1:0]  pre_n,
  output logic [SYNC_W-1:0] sync_q,
  output logic [HLEN_W-1:0] hdr_n,
  output logic [HDR_W-1:0]  hdr_q,
  output logic              len_en_q,
  output logic [LEN_W-1:0]  pay_n
);

  // At least one preamble byte is always sent.
  function automatic logic [PRE_W-1:0] fix_pre(input logic [PRE_W-1:0] v);
    return (v == '0) ? PRE_W'(1) : v;
  endfunction

  // Header count never exceeds the header source width.
  function automatic logic [HLEN_W-1:0] clamp_hdr(input logic [HLEN_W-1:0] v);
    return (int'(v) > HDR_MAX) ? HLEN_W'(HDR_MAX) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_n    <= PRE_W'(1);
      sync_q   <= '0;
      hdr_n    <= '0;
      hdr_q    <= '0;
      len_en_q <= 1'b0;
      pay_n    <= '0;
    end else if (capture) begin
      pre_n    <= fix_pre(pre_len_in);
      sync_q   <= sync_in;
      hdr_n    <= clamp_hdr(hdr_len_in);
      hdr_q    <= hdr_in;
      len_en_q <= len_en_in;
      pay_n    <= pkt_len_in;
    end
  end

endmodule

// File: rtl/pkt_tx_frame_ctrl.sv
module pkt_tx_frame_ctrl
  import pkt_tx_pkg::*;
#(
  parameter int PRE_W   = 4,
  parameter int HDR_MAX = 4,
  parameter int SYNC_W  = 16,
  parameter int LEN_W   = 8,
  localparam int HLEN_W     = $clog2(HDR_MAX + 1),
  localparam int HDR_W      = 8 * HDR_MAX,
  localparam int SYNC_BYTES = SYNC_W / 8,
  localparam int IDX_W      = (LEN_W > PRE_W) ? LEN_W : PRE_W,
  localparam int CNT_W      = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_last,
  input  logic              fifo_empty_i,
  input  logic [7:0]        fifo_data_i,
  input  logic [PRE_W-1:0]  pre_n,
  input  logic [SYNC_W-1:0] sync_q,
  input  logic [HLEN_W-1:0] hdr_n,
  input  logic [HDR_W-1:0]  hdr_q,
  input  logic              len_en_q,
  input  logic [LEN_W-1:0]  pay_n,
  output logic              busy,
  output logic              start_acc,
  output logic              load,
  output logic [7:0]        load_byte,
  output logic              fifo_rd_o,
  output logic              pkt_done,
  output logic              pkt_abort
);

  field_e           field_q, nxt_f;
  logic [IDX_W-1:0] idx_q, nxt_i;
  logic             step;
  logic [7:0]       sel_byte;

  // True when index i is the final one of a section holding n bytes.
  function automatic logic at_end(input logic [IDX_W-1:0] i, input logic [CNT_W-1:0] n);
    return (CNT_W'(i) + CNT_W'(1)) >= n;
  endfunction

  // First non-empty section after the length slot.
  function automatic field_e after_len(input logic has_pay);
    return has_pay ? F_PAY : F_IDLE;
  endfunction

  function automatic field_e after_hdr(input logic has_len, input logic has_pay);
    return has_len ? F_LEN : after_len(has_pay);
  endfunction

  function automatic field_e after_sync(input logic has_hdr, input logic has_len,
                                        input logic has_pay);
    return has_hdr ? F_HDR : after_hdr(has_len, has_pay);
  endfunction

  // Byte pos of a word, counted from its most significant byte.
  function automatic logic [7:0] sync_byte(input logic [SYNC_W-1:0] w, input int pos);
    return 8'(w >> (8 * (SYNC_BYTES - 1 - pos)));
  endfunction

  function automatic logic [7:0] hdr_byte(input logic [HDR_W-1:0] w, input int used,
                                          input int pos);
    return 8'(w >> (8 * (used - 1 - pos)));
  endfunction

  assign busy      = (field_q != F_IDLE);
  assign start_acc = start_i && !busy;
  assign step      = busy && byte_last;

  always_comb begin
    nxt_f = field_q;
    nxt_i = idx_q + 1'b1;
    case (field_q)
      F_PRE: begin
        if (at_end(idx_q, CNT_W'(pre_n))) begin
          nxt_f = F_SYNC;
          nxt_i = '0;
        end
      end
      F_SYNC: begin
        if (at_end(idx_q, CNT_W'(SYNC_BYTES))) begin
          nxt_f = after_sync(hdr_n != '0, len_en_q, pay_n != '0);
          nxt_i = '0;
        end
      end
      F_HDR: begin
        if (at_end(idx_q, CNT_W'(hdr_n))) begin
          nxt_f = after_hdr(len_en_q, pay_n != '0);
          nxt_i = '0;
        end
      end
      F_LEN: begin
        nxt_f = after_len(pay_n != '0);
        nxt_i = '0;
      end
      F_PAY: begin
        if (at_end(idx_q, CNT_W'(pay_n))) begin
          nxt_f = F_IDLE;
          nxt_i = '0;
        end
      end
      default: begin
        nxt_f = F_IDLE;
        nxt_i = '0;
      end
    endcase
  end

  always_comb begin
    case (nxt_f)
      F_PRE:   sel_byte = PRE_BYTE;
      F_SYNC:  sel_byte = sync_byte(sync_q, int'(nxt_i));
      F_HDR:   sel_byte = hdr_byte(hdr_q, int'(hdr_n), int'(nxt_i));
      F_LEN:   sel_byte = 8'(pay_n);
      F_PAY:   sel_byte = fifo_data_i;
      default: sel_byte = 8'h00;
    endcase
  end

  // Named frame events, observed by the checker.
  assign pkt_abort = step && (nxt_f == F_PAY) && fifo_empty_i;
  assign pkt_done  = step && (nxt_f == F_IDLE);
  assign fifo_rd_o = step && (nxt_f == F_PAY) && !fifo_empty_i;
  assign load      = start_acc || (step && (nxt_f != F_IDLE) && !pkt_abort);
  assign load_byte = start_acc ? PRE_BYTE : sel_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= F_IDLE;
      idx_q   <= '0;
    end else if (start_acc) begin
      field_q <= F_PRE;
      idx_q   <= '0;
    end else if (step) begin
      field_q <= pkt_abort ? F_IDLE : nxt_f;
      idx_q   <= nxt_i;
    end
  end

endmodule

// File: rtl/pkt_tx_shifter.sv
module pkt_tx_shifter
  import pkt_tx_pkg::*;
#(
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              shift_en,
  output logic              ser_bit,
  output logic              byte_last
);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= load_byte;
      cnt_q <= '0;
    end else if (shift_en) begin
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ser_bit   = sh_q[BYTE_W-1];
  assign byte_last = (cnt_q == CNT_W'(BYTE_W - 1));

endmodule

// File: rtl/pkt_tx_irq.sv
module pkt_tx_irq #(
  parameter int N_FLAGS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_i,
  input  logic               clr_i,
  output logic [N_FLAGS-1:0] flag_o
);

  // Set wins over a clear arriving on the same edge.
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[g] <= 1'b0;
      else if (set_i[g])   flag_o[g] <= 1'b1;
      else if (clr_i)      flag_o[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/pkt_tx_seq.sv
module pkt_tx_seq
  import pkt_tx_pkg::*;
#(
  parameter int PRE_W   = 4,
  parameter int HDR_MAX = 4,
  parameter int SYNC_W  = 16,
  parameter int LEN_W   = 8,
  localparam int HLEN_W = $clog2(HDR_MAX + 1),
  localparam int HDR_W  = 8 * HDR_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              irq_rd_i,
  input  logic [PRE_W-1:0]  cfg_pre_len,
  input  logic [SYNC_W-1:0] cfg_sync,
  input  logic [HLEN_W-1:0] cfg_hdr_len,
  input  logic [HDR_W-1:0]  cfg_hdr,
  input  logic              cfg_len_en,
  input  logic [LEN_W-1:0]  cfg_pkt_len,
  input  logic              fifo_empty_i,
  input  logic [7:0]        fifo_data_i,
  output logic              fifo_rd_o,
  output logic              tx_bit_o,
  output logic              tx_vld_o,
  output logic              tx_busy_o,
  output logic              irq_sent_o,
  output logic              irq_unf_o
);

  logic [PRE_W-1:0]  pre_n;
  logic [SYNC_W-1:0] sync_q;
  logic [HLEN_W-1:0] hdr_n;
  logic [HDR_W-1:0]  hdr_q;
  logic              len_en_q;
  logic [LEN_W-1:0]  pay_n;
  logic              busy, start_acc, load, byte_last, ser_bit;
  logic              pkt_done, pkt_abort;
  logic [7:0]        load_byte;
  logic [1:0]        flags;

  pkt_tx_cfg_hold #(
    .PRE_W(PRE_W), .HDR_MAX(HDR_MAX), .SYNC_W(SYNC_W), .LEN_W(LEN_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(start_acc),
    .pre_len_in(cfg_pre_len), .sync_in(cfg_sync), .hdr_len_in(cfg_hdr_len),
    .hdr_in(cfg_hdr), .len_en_in(cfg_len_en), .pkt_len_in(cfg_pkt_len),
    .pre_n(pre_n), .sync_q(sync_q), .hdr_n(hdr_n), .hdr_q(hdr_q),
    .len_en_q(len_en_q), .pay_n(pay_n)
  );

  pkt_tx_frame_ctrl #(
    .PRE_W(PRE_W), .HDR_MAX(HDR_MAX), .SYNC_W(SYNC_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_last(byte_last),
    .fifo_empty_i(fifo_empty_i), .fifo_data_i(fifo_data_i),
    .pre_n(pre_n), .sync_q(sync_q), .hdr_n(hdr_n), .hdr_q(hdr_q),
    .len_en_q(len_en_q), .pay_n(pay_n),
    .busy(busy), .start_acc(start_acc), .load(load), .load_byte(load_byte),
    .fifo_rd_o(fifo_rd_o), .pkt_done(pkt_done), .pkt_abort(pkt_abort)
  );

  pkt_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .shift_en(busy), .ser_bit(ser_bit), .byte_last(byte_last)
  );

  pkt_tx_irq #(.N_FLAGS(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i({pkt_abort, pkt_done}),
    .clr_i(irq_rd_i), .flag_o(flags)
  );

  assign tx_busy_o  = busy;
  assign tx_vld_o   = busy;
  assign tx_bit_o   = busy && ser_bit;
  assign irq_sent_o = flags[0];
  assign irq_unf_o  = flags[1];

endmodule

// File: rtl/pkt_tx_seq_chk.sv
module pkt_tx_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic irq_rd_i,
  input logic fifo_empty_i,
  input logic fifo_rd_o,
  input logic tx_busy_o,
  input logic irq_sent_o,
  input logic irq_unf_o,
  input logic byte_last,
  input logic pkt_done,
  input logic pkt_abort
);

  // R1
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy_o) |-> $past(start_i));

  // R5
  pop_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> (tx_busy_o && !fifo_empty_i && byte_last));

  // R5
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy_o && !pkt_done && !pkt_abort) |=> tx_busy_o);

  // R5
  ends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done || pkt_abort) |=> !tx_busy_o);

  // R7
  sent_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sent_o) |-> $past(pkt_done));

  // R7
  sent_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sent_o && !irq_rd_i) |=> irq_sent_o);

  // R7
  sent_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> irq_sent_o);

  // R8
  unf_on_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_abort |=> (irq_unf_o && !$rose(irq_sent_o)));

  // R8
  unf_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_unf_o) |-> $past(fifo_empty_i));

endmodule

bind pkt_tx_seq pkt_tx_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .irq_rd_i(irq_rd_i),
  .fifo_empty_i(fifo_empty_i), .fifo_rd_o(fifo_rd_o), .tx_busy_o(tx_busy_o),
  .irq_sent_o(irq_sent_o), .irq_unf_o(irq_unf_o), .byte_last(byte_last),
  .pkt_done(pkt_done), .pkt_abort(pkt_abort)
);

// File: tb/pkt_tx_seq_test.sv
module pkt_tx_seq_test;

  localparam logic [15:0] SYNC_WORD = 16'h2DD4;

  typedef struct packed {
    logic [3:0]  pre;
    logic [2:0]  hlen;
    logic [31:0] hdr;
    logic        len_en;
    logic [7:0]  plen;
    logic [7:0]  fill;
    logic [7:0]  nbytes;
    logic        sent;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 3'd0, 32'h0,         1'b0, 8'd3, 8'd3, 8'd7,  1'b1},
    '{4'd1, 3'd2, 32'h0000_A1B2, 1'b1, 8'd4, 8'd4, 8'd10, 1'b1},
    '{4'd0, 3'd1, 32'h0000_00C3, 1'b0, 8'd2, 8'd2, 8'd6,  1'b1},
    '{4'd3, 3'd4, 32'h1122_3344, 1'b1, 8'd0, 8'd0, 8'd10, 1'b1},
    '{4'd2, 3'd0, 32'h0,         1'b1, 8'd5, 8'd2, 8'd7,  1'b0},
    '{4'd2, 3'd7, 32'h5566_7788, 1'b0, 8'd1, 8'd1, 8'd9,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, irq_rd_i = 1'b0;
  logic [3:0]  cfg_pre_len = '0;
  logic [15:0] cfg_sync = SYNC_WORD;
  logic [2:0]  cfg_hdr_len = '0;
  logic [31:0] cfg_hdr = '0;
  logic        cfg_len_en = 1'b0;
  logic [7:0]  cfg_pkt_len = '0;
  logic        fifo_empty_i;
  logic [7:0]  fifo_data_i;
  logic        fifo_rd_o, tx_bit_o, tx_vld_o, tx_busy_o, irq_sent_o, irq_unf_o;

  logic [7:0] fq [0:63];
  int         rd_ptr = 0;
  int         tail = 0;
  logic       got [0:4095];
  int         nbits;
  logic [7:0] exp_b [0:511];
  int         exp_n;
  int         total = 0, bad = 0;

  always #10 clk = ~clk;

  assign fifo_empty_i = (rd_ptr == tail);
  assign fifo_data_i  = fq[rd_ptr & 63];
  always @(posedge clk) if (fifo_rd_o && rd_ptr != tail) rd_ptr <= rd_ptr + 1;

  pkt_tx_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .irq_rd_i(irq_rd_i),
    .cfg_pre_len(cfg_pre_len), .cfg_sync(cfg_sync), .cfg_hdr_len(cfg_hdr_len),
    .cfg_hdr(cfg_hdr), .cfg_len_en(cfg_len_en), .cfg_pkt_len(cfg_pkt_len),
    .fifo_empty_i(fifo_empty_i), .fifo_data_i(fifo_data_i), .fifo_rd_o(fifo_rd_o),
    .tx_bit_o(tx_bit_o), .tx_vld_o(tx_vld_o), .tx_busy_o(tx_busy_o),
    .irq_sent_o(irq_sent_o), .irq_unf_o(irq_unf_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int n, input int base);
    for (int k = 0; k < n; k++) fq[(rd_ptr + k) & 63] = 8'(base + k);
    tail = rd_ptr + n;
  endtask

  task automatic push(input logic [7:0] b);
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  // Expected frame restated from R2..R5 and R8.
  task automatic build_exp(input int pre, input int hlen, input logic [31:0] hdr,
                           input bit len_en, input int plen);
    int avail = tail - rd_ptr;
    exp_n = 0;
    if (pre == 0) pre = 1;
    repeat (pre) push(8'hAA);
    push(SYNC_WORD[15:8]);
    push(SYNC_WORD[7:0]);
    if (hlen > 4) hlen = 4;
    for (int k = hlen - 1; k >= 0; k--) push(hdr[8*k +: 8]);
    if (len_en) push(8'(plen));
    for (int k = 0; k < plen && k < avail; k++) push(fq[(rd_ptr + k) & 63]);
  endtask

  task automatic run_pkt(input bit rd_last, input bit poke);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(tx_vld_o === 1'b1, "R1 first bit one cycle after start", tx_vld_o, 1);
    nbits = 0;
    while (tx_vld_o === 1'b1 && nbits < 4096) begin
      got[nbits] = tx_bit_o;
      nbits++;
      if (rd_last && nbits == exp_n * 8) irq_rd_i = 1'b1;
      if (poke && nbits == 5) begin
        start_i = 1'b1;
        cfg_pkt_len = 8'd9;
        cfg_hdr_len = 3'd0;
        cfg_pre_len = 4'd5;
      end
      @(negedge clk);
      irq_rd_i = 1'b0;
      start_i = 1'b0;
    end
  endtask

  task automatic cmp_frame(input string tag);
    int bad_k = -1;
    logic [7:0] ab = '0, eb = '0;
    chk(nbits == exp_n * 8, {tag, " R5 bit count"}, nbits, exp_n * 8);
    for (int k = 0; k < exp_n && k * 8 + 7 < nbits; k++) begin
      logic [7:0] b = '0;
      for (int j = 0; j < 8; j++) b = {b[6:0], got[k*8 + j]};
      if (b !== exp_b[k] && bad_k < 0) begin
        bad_k = k; ab = b; eb = exp_b[k];
      end
    end
    chk(bad_k < 0, {tag, " R1 R2 R3 R4 frame bytes"}, ab, eb);
  endtask

  task automatic clear_flags();
    irq_rd_i = 1'b1;
    @(negedge clk);
    irq_rd_i = 1'b0;
    chk(!irq_sent_o && !irq_unf_o, "R7 R8 read strobe clears flags",
        {irq_sent_o, irq_unf_o}, 0);
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (tx_vld_o !== 1'b0 || tx_busy_o !== 1'b0) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R5 sequencer hung act=busy exp=idle");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk({tx_vld_o, tx_bit_o, tx_busy_o, fifo_rd_o, irq_sent_o, irq_unf_o} == 6'b0,
        "R10 outputs during reset",
        {tx_vld_o, tx_bit_o, tx_busy_o, fifo_rd_o, irq_sent_o, irq_unf_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tx_vld_o, tx_bit_o, tx_busy_o, fifo_rd_o, irq_sent_o, irq_unf_o} == 6'b0,
        "R10 outputs after reset",
        {tx_vld_o, tx_bit_o, tx_busy_o, fifo_rd_o, irq_sent_o, irq_unf_o}, 0);

    // Vector table: R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      int left_exp;
      cfg_pre_len = VECS[v].pre;
      cfg_hdr_len = VECS[v].hlen;
      cfg_hdr     = VECS[v].hdr;
      cfg_len_en  = VECS[v].len_en;
      cfg_pkt_len = VECS[v].plen;
      fill(int'(VECS[v].fill), 8'h30 + 16 * v);
      clear_flags();
      build_exp(int'(VECS[v].pre), int'(VECS[v].hlen), VECS[v].hdr,
                VECS[v].len_en, int'(VECS[v].plen));
      chk(exp_n == int'(VECS[v].nbytes), "R5 table byte count", exp_n, VECS[v].nbytes);
      left_exp = (VECS[v].plen > VECS[v].fill) ? 0 : int'(VECS[v].fill - VECS[v].plen);
      run_pkt(1'b0, 1'b0);
      cmp_frame($sformatf("vec%0d", v));
      chk(tx_busy_o === 1'b0, "R5 idle after frame", tx_busy_o, 0);
      chk(irq_sent_o === VECS[v].sent, "R7 sent flag", irq_sent_o, VECS[v].sent);
      chk(irq_unf_o === !VECS[v].sent, "R8 underflow flag", irq_unf_o, !VECS[v].sent);
      chk(tail - rd_ptr == left_exp, "R5 FIFO pops", tail - rd_ptr, left_exp);
    end

    // R6: length 3, nine queued, three starts
    cfg_pre_len = 4'd1; cfg_hdr_len = 3'd0; cfg_len_en = 1'b0; cfg_pkt_len = 8'd3;
    fill(9, 8'hB0);
    for (int p = 0; p < 3; p++) begin
      clear_flags();
      build_exp(1, 0, 32'h0, 1'b0, 3);
      run_pkt(1'b0, 1'b0);
      cmp_frame($sformatf("R6 pkt%0d", p));
      chk(tail - rd_ptr == 6 - 3 * p, "R6 bytes left after packet", tail - rd_ptr, 6 - 3 * p);
      chk(irq_sent_o === 1'b1, "R6 sent per packet", irq_sent_o, 1);
      quiet(20, "R6 no resume without start");
    end

    // R9: start and config change while busy
    cfg_pre_len = 4'd2; cfg_hdr_len = 3'd1; cfg_hdr = 32'h0000_00EE;
    cfg_len_en = 1'b1; cfg_pkt_len = 8'd2;
    fill(4, 8'h60);
    clear_flags();
    build_exp(2, 1, 32'h0000_00EE, 1'b1, 2);
    run_pkt(1'b0, 1'b1);
    cmp_frame("R9 busy start");
    chk(tail - rd_ptr == 2, "R9 payload count kept", tail - rd_ptr, 2);
    quiet(12, "R9 busy start ignored");

    // R7: sticky, set-wins collision, lone clear
    cfg_pre_len = 4'd1; cfg_hdr_len = 3'd0; cfg_len_en = 1'b0; cfg_pkt_len = 8'd1;
    fill(2, 8'h70);
    clear_flags();
    build_exp(1, 0, 32'h0, 1'b0, 1);
    run_pkt(1'b0, 1'b0);
    cmp_frame("R7 first");
    repeat (5) @(negedge clk);
    chk(irq_sent_o === 1'b1, "R7 flag sticky", irq_sent_o, 1);
    build_exp(1, 0, 32'h0, 1'b0, 1);
    run_pkt(1'b1, 1'b0);
    cmp_frame("R7 collision");
    chk(irq_sent_o === 1'b1, "R7 set wins over read", irq_sent_o, 1);
    irq_rd_i = 1'b1;
    @(negedge clk);
    irq_rd_i = 1'b0;
    chk(irq_sent_o === 1'b0, "R7 lone read clears", irq_sent_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule